// File: doc/BRIEF.md
# Sequential Packet Buffer Access Pointer

This block lets a host stream bytes into and out of a 2K×8 packet buffer through three byte-wide registers: a pointer-high register, a pointer-low register and a data register. The host first sets the upper address bits and two mode bits. One mode bit picks reads or writes, and the other turns on stepping of the pointer. The host then writes the lower eight address bits. After that, each access to the data register moves one byte between the host and the buffer. If stepping is on, the pointer then advances by one.

In read mode the block fetches ahead. A write to pointer-low starts a fetch of the addressed byte into the data register, so the first data read returns that byte at once. Each later data read returns the byte held in the data register and then fetches the byte at the new pointer. A write-mode data access writes the host byte straight into the buffer. The host can read the pointer back at any time to see how many transfers have completed. To change direction, the host reloads the pointer.

A small sequencer runs the fetch. Its states are ST_IDLE, ST_FETCH and ST_CAPTURE:
- ST_IDLE moves to ST_FETCH on a pointer-low write in read mode ("load") or on an accepted read-mode data read ("advance").
- ST_FETCH issues the buffer read. It moves to ST_CAPTURE ("issue"), or stays in ST_FETCH on a new read-mode pointer-low write ("restart").
- ST_CAPTURE latches the returned byte and moves to ST_IDLE ("settle"), or to ST_FETCH on a read-mode pointer-low write ("restart").

The buffer returns read data one cycle after the read request.

Top module: `bufptr_access`

## Requirements
- R1: After reset the pointer is 000H, the block is in write mode and stepping is off. Pointer-high and pointer-low both read as 00H.
- R2: The register offsets are 2 for pointer-high, 3 for pointer-low and 4 for data. Pointer-high holds bit 7 = read mode (1 = read, 0 = write), bit 6 = stepping on, and bits 2:0 = address bits 10:8. Bits 5:3 read as 0. Pointer-low holds address bits 7:0. Both registers read back the live pointer.
- R3: A pointer-low write while read mode is set raises the buffer read request in the next cycle. The addressed byte is in the data register three cycles after the write.
- R4: A write-mode data write writes the host byte to the buffer at the pointer in the same cycle. A data write in read mode is ignored: the buffer is not written and the pointer does not move.
- R5: With stepping on, each accepted data access advances the pointer by one, wrapping from 7FFH to 000H.
- R6: With stepping off, data accesses leave the pointer unchanged, so repeated accesses target one address.
- R7: A read-mode data read returns the prefetched byte and then fetches the byte at the updated pointer. A data read in write mode returns the data register and does not move the pointer.
- R8: A data access while a fetch is in progress (sequencer not in ST_IDLE) is ignored: the pointer does not move and the buffer is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Register write strobe, one cycle |
| host_rd | input | 1 | Register read strobe, one cycle |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data for the addressed register |
| ram_addr | output | 11 | Buffer address (the pointer) |
| ram_rd | output | 1 | Buffer read request; data returns next cycle |
| ram_we | output | 1 | Buffer write enable |
| ram_wdata | output | 8 | Buffer write data |
| ram_rdata | input | 8 | Buffer read data |

## Verification
The hardest case to reach is a data access that lands while the fetch sequencer is still busy. To get there, the stimulus issues a data read in the cycle right after a read-mode pointer-low write, then a data write in the cycle after that. The pointer is then read back, and the fetched byte is checked to be the one at the loaded address. The wrap from 7FFH to 000H is reached by loading the pointer at 7FEH and making three stepped transfers in each direction.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_CAPTURE = 2'd2
    } seq_state_t;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_PTR_HI = 3'h2;
    localparam logic [REG_AW-1:0] OFS_PTR_LO = 3'h3;
    localparam logic [REG_AW-1:0] OFS_DATA   = 3'h4;

endpackage

// File: rtl/bufptr_counter.sv
module bufptr_counter #(
    parameter int ADDR_W = 11,
    localparam int HI_W  = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [HI_W-1:0]   hi_bits,
    input  logic              new_rd,
    input  logic              new_inc,
    input  logic              lo_we,
    input  logic [7:0]        lo_bits,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              mode_rd,
    output logic              mode_inc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            mode_rd  <= 1'b0;
            mode_inc <= 1'b0;
        end else if (hi_we) begin
            ptr[ADDR_W-1:8] <= hi_bits;
            mode_rd         <= new_rd;
            mode_inc        <= new_inc;
        end else if (lo_we) begin
            ptr[7:0] <= lo_bits;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/bufptr_seq.sv
module bufptr_seq
    import bufptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_we,
    input  logic       data_rd,
    input  logic       data_wr,
    input  logic       mode_rd,
    input  logic       mode_inc,
    output seq_state_t state,
    output logic       step,
    output logic       ram_rd,
    output logic       ram_we,
    output logic       cap
);

    seq_state_t state_nx;
    logic       rd_go;
    logic       wr_go;
    logic       load_go;

    always_comb begin
        rd_go   = (state == ST_IDLE) && data_rd && mode_rd;
        wr_go   = (state == ST_IDLE) && data_wr && !mode_rd;
        load_go = lo_we && mode_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (load_go || rd_go) state_nx = ST_FETCH;
            ST_FETCH:   state_nx = load_go ? ST_FETCH : ST_CAPTURE;
            ST_CAPTURE: state_nx = load_go ? ST_FETCH : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        step   = (rd_go || wr_go) && mode_inc;
        ram_we = wr_go;
        ram_rd = (state == ST_FETCH);
        cap    = (state == ST_CAPTURE);
    end

endmodule

// File: rtl/bufptr_access.sv
module bufptr_access
    import bufptr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);

    localparam int HI_W  = ADDR_W - 8;
    localparam int PAD_W = 6 - HI_W;

    logic [ADDR_W-1:0] ptr_q;
    logic              mode_rd;
    logic              mode_inc;
    logic [DATA_W-1:0] data_q;
    logic              hi_we;
    logic              lo_we;
    logic              data_rd;
    logic              data_wr;
    logic              step;
    logic              cap;
    seq_state_t        seq_state;

    always_comb begin
        hi_we   = host_wr && (host_addr == OFS_PTR_HI);
        lo_we   = host_wr && (host_addr == OFS_PTR_LO);
        data_wr = host_wr && (host_addr == OFS_DATA);
        data_rd = host_rd && (host_addr == OFS_DATA);
    end

    bufptr_counter #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_we    (hi_we),
        .hi_bits  (host_wdata[HI_W-1:0]),
        .new_rd   (host_wdata[7]),
        .new_inc  (host_wdata[6]),
        .lo_we    (lo_we),
        .lo_bits  (host_wdata),
        .step     (step),
        .ptr      (ptr_q),
        .mode_rd  (mode_rd),
        .mode_inc (mode_inc)
    );

    bufptr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (lo_we),
        .data_rd  (data_rd),
        .data_wr  (data_wr),
        .mode_rd  (mode_rd),
        .mode_inc (mode_inc),
        .state    (seq_state),
        .step     (step),
        .ram_rd   (ram_rd),
        .ram_we   (ram_we),
        .cap      (cap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   data_q <= '0;
        else if (cap) data_q <= ram_rdata;
    end

    always_comb begin
        ram_addr  = ptr_q;
        ram_wdata = host_wdata[DATA_W-1:0];
        unique case (host_addr)
            OFS_PTR_HI: host_rdata = {mode_rd, mode_inc, {PAD_W{1'b0}}, ptr_q[ADDR_W-1:8]};
            OFS_PTR_LO: host_rdata = ptr_q[7:0];
            OFS_DATA:   host_rdata = data_q;
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bufptr_access_chk.sv
module bufptr_access_chk
    import bufptr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic              ram_rd,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              mode_rd,
    input logic              mode_inc,
    input seq_state_t        seq_state
);

    logic data_acc;
    logic lo_load;
    assign data_acc = (host_rd || host_wr) && (host_addr == OFS_DATA);
    assign lo_load  = host_wr && (host_addr == OFS_PTR_LO);

    // R4: buffer writes only from a write-mode data write
    assert_wr_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_wr && host_addr == OFS_DATA && !mode_rd));

    // R3: read-mode pointer-low write requests a fetch next cycle
    assert_prefetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_load && mode_rd) |=> ram_rd);

    // R5: stepping wraps at the top of the buffer
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && mode_inc && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

    // R6: no stepping, pointer holds across data accesses
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !mode_inc) |=> (ptr_q == $past(ptr_q)));

    // R7: each fetch is a single read request unless restarted
    assert_single_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd && !lo_load) |=> !ram_rd);

    // R8: data accesses during a fetch leave the pointer alone
    assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && seq_state != ST_IDLE) |=> (ptr_q == $past(ptr_q)));

    // R8: no buffer write while the sequencer is busy
    assert_busy_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != ST_IDLE) |-> !ram_we);

endmodule

bind bufptr_access bufptr_access_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .ram_rd    (ram_rd),
    .ram_we    (ram_we),
    .ptr_q     (ptr_q),
    .mode_rd   (mode_rd),
    .mode_inc  (mode_inc),
    .seq_state (seq_state)
);

// File: tb/tb_bufptr_access.sv
`timescale 1ns/1ps
module tb_bufptr_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [10:0] ram_addr;
    logic        ram_rd;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mem [0:2047];

    always #2 clk = ~clk;

    bufptr_access dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // buffer model: one-cycle read latency
    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= mem[ram_addr];
    end

    // monitor: compares every host read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && host_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %02h expected none", host_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, input logic [7:0] e, input string t);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state, R2 readback layout
        reg_rd(3'h2, 8'h00, "R1 ptr-high after reset");
        reg_rd(3'h3, 8'h00, "R1 ptr-low after reset");

        // R4/R5: write mode, stepping, wrap 7FE -> 7FF -> 000
        reg_wr(3'h2, 8'h47);
        reg_wr(3'h3, 8'hFE);
        reg_wr(3'h4, 8'hA1);
        reg_wr(3'h4, 8'hB2);
        reg_wr(3'h4, 8'hC3);
        reg_rd(3'h3, 8'h01, "R5 ptr-low after wrap");
        reg_rd(3'h2, 8'h40, "R2 ptr-high mode bits and A10-8");

        // R6: write mode, no stepping at 100H
        reg_wr(3'h2, 8'h01);
        reg_wr(3'h3, 8'h00);
        reg_wr(3'h4, 8'h11);
        reg_wr(3'h4, 8'h22);
        reg_rd(3'h3, 8'h00, "R6 ptr-low held");
        reg_rd(3'h2, 8'h01, "R6 ptr-high held");

        // R3/R7/R5: read mode with stepping from 7FEH
        reg_wr(3'h2, 8'hC7);
        reg_wr(3'h3, 8'hFE);
        idle(3);
        reg_rd(3'h4, 8'hA1, "R3 prefetched first byte");
        idle(3);
        reg_rd(3'h4, 8'hB2, "R7 next byte after read");
        idle(3);
        reg_rd(3'h4, 8'hC3, "R5 read across wrap");
        idle(3);
        reg_rd(3'h3, 8'h01, "R5 ptr-low count after reads");
        reg_rd(3'h2, 8'hC0, "R2 ptr-high read mode");

        // R6: read mode without stepping at 100H (last write kept 22)
        reg_wr(3'h2, 8'h81);
        reg_wr(3'h3, 8'h00);
        idle(3);
        reg_rd(3'h4, 8'h22, "R6 repeated read 1");
        idle(3);
        reg_rd(3'h4, 8'h22, "R6 repeated read 2");
        idle(3);

        // R4: data write ignored in read mode
        reg_wr(3'h4, 8'h55);
        reg_wr(3'h3, 8'h00);
        idle(3);
        reg_rd(3'h4, 8'h22, "R4 read-mode write ignored");
        idle(3);
        reg_rd(3'h3, 8'h00, "R4 ptr unchanged");

        // R7: data read in write mode does not move the pointer
        reg_wr(3'h2, 8'h40);
        reg_wr(3'h3, 8'h20);
        reg_rd(3'h4, 8'h22, "R7 write-mode read returns data reg");
        reg_rd(3'h3, 8'h20, "R7 write-mode read leaves ptr");

        // R8: accesses during a fetch are ignored
        reg_wr(3'h3, 8'h10);
        reg_wr(3'h4, 8'h31);
        reg_wr(3'h4, 8'h32);
        reg_wr(3'h2, 8'hC0);
        reg_wr(3'h3, 8'h10);
        reg_rd(3'h4, 8'h22, "R8 read during fetch returns stale");
        reg_wr(3'h4, 8'h77);
        idle(2);
        reg_rd(3'h3, 8'h10, "R8 ptr unmoved by busy accesses");
        reg_rd(3'h4, 8'h31, "R8 fetched byte at loaded address");
        idle(3);
        reg_rd(3'h4, 8'h32, "R8 following byte intact");
        idle(3);
        reg_rd(3'h3, 8'h12, "R5 ptr after two reads");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule